// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral interface master that a processor drives through a small word-addressed register window. Software loads an outgoing word, writes a control word that fixes the serial clock idle level and sampling phase, the active level of the chip select, which of four chip selects to use, the frame length and a clock divider, and sets a go bit in the same write. The block then runs one frame of 1 to 32 bits. It shifts the outgoing word out most significant bit first and collects the incoming line into a receive word.

The go bit reads back as 1 for as long as the frame is in progress and drops by itself when the frame is over, so software polls it. After it drops, the receive word holds the frame's incoming bits, right-aligned. While a frame runs, the outgoing word and the control word are frozen, so a stray write cannot corrupt a frame in progress. Serial clock, data-out and chip selects all come straight from registered state.

Top module: `spi_mm_master`

## Requirements
- R1: Byte offset 0x00 reads the receive word, 0x04 reads back the outgoing word, and 0x08 reads the control word. Offsets 0x0C through 0x1C read zero and ignore writes. The control fields are: bit 0 enable, bit 1 master, bit 2 go, bit 4 clock-idle select, bit 5 phase, bit 7 select polarity, bits 12:8 length minus one, bits 18:16 rate, bits 25:24 select index. All other control bits read zero, and every control bit and register reads zero after reset.
- R2: A control write with bit 2 set, while bits 0 and 1 are both 1 in the same write, starts a frame. Bit 2 reads 1 until the frame ends and then reads 0.
- R3: A control write with bit 2 set while bit 0 or bit 1 is 0 starts nothing. Bit 2 reads 0, no chip select goes active and the serial clock stays at its idle level.
- R4: A frame has length-field+1 bits and the serial clock makes exactly twice that many transitions. The outgoing bits are bit (length-field) of the outgoing word down to bit 0, in that order.
- R5: After a frame, offset 0x00 holds the incoming bits right-aligned, with the last bit received in bit 0 and all bits above the frame length zero.
- R6: Every serial clock half period lasts 2^(rate+1) system clock cycles, so the full period is 2^(rate+2) cycles.
- R7: With bit 4 = 1 the serial clock idles low. With bit 4 = 0 it idles high.
- R8: With bit 5 = 0, outgoing data is valid before the first transition, the incoming line is sampled on transitions away from idle, and data changes on transitions back to idle. With bit 5 = 1, data changes on transitions away from idle and is sampled on transitions back to idle.
- R9: During a frame, only the chip select numbered by bits 25:24 is active, at the level given by bit 7 (1 = active high). Every other chip select, and all of them outside a frame, sit at the opposite level.
- R10: The chip select goes active one half period before the first clock transition. It goes inactive one half period after the last transition, and bit 2 clears at that same moment.
- R11: Writes to the outgoing word or the control word while a frame is in progress have no effect, including a write that sets bit 2.
- R12: The data-out line is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are not decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NUM_CS | Chip selects |

## Verification
A misplaced bit pointer or a phase error first appears in the bits a modelled slave captures from the data-out line, and in the receive word. Both are visible by the end of the first affected frame. A divider fault changes the spacing of serial clock transitions at the very first transition, so the half period is measured on every edge, together with the lead and trail time of the chip select. A stuck frame state leaves the go bit set, and a lost freeze shows up as a changed readback of the outgoing or control word right after the frame that was disturbed.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

   localparam int WORD_W = 32;
   localparam int LEN_W  = 5;
   localparam int RATE_W = 3;
   localparam int SEL_W  = 2;

   // word indices of the register window
   localparam logic [2:0] IDX_RXD = 3'd0;
   localparam logic [2:0] IDX_TXD = 3'd1;
   localparam logic [2:0] IDX_CTL = 3'd2;

   // control word bit positions
   localparam int B_EN    = 0;
   localparam int B_MST   = 1;
   localparam int B_GO    = 2;
   localparam int B_CPOL  = 4;
   localparam int B_CPHA  = 5;
   localparam int B_CSPOL = 7;
   localparam int B_LEN   = 8;
   localparam int B_RATE  = 16;
   localparam int B_SEL   = 24;

   typedef struct packed {
      logic [SEL_W-1:0]  sel;
      logic [RATE_W-1:0] rate;
      logic [LEN_W-1:0]  len_m1;
      logic              cspol;
      logic              cpha;
      logic              cpol;
      logic              mst;
      logic              en;
   } ctl_t;

   function automatic ctl_t ctl_unpack(input logic [WORD_W-1:0] w);
      ctl_t c;
      c.en     = w[B_EN];
      c.mst    = w[B_MST];
      c.cpol   = w[B_CPOL];
      c.cpha   = w[B_CPHA];
      c.cspol  = w[B_CSPOL];
      c.len_m1 = w[B_LEN +: LEN_W];
      c.rate   = w[B_RATE +: RATE_W];
      c.sel    = w[B_SEL +: SEL_W];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] ctl_pack(input ctl_t c, input logic go);
      logic [WORD_W-1:0] w;
      w                  = '0;
      w[B_EN]            = c.en;
      w[B_MST]           = c.mst;
      w[B_GO]            = go;
      w[B_CPOL]          = c.cpol;
      w[B_CPHA]          = c.cpha;
      w[B_CSPOL]         = c.cspol;
      w[B_LEN +: LEN_W]  = c.len_m1;
      w[B_RATE +: RATE_W] = c.rate;
      w[B_SEL +: SEL_W]  = c.sel;
      return w;
   endfunction

endpackage

// File: rtl/spi_mm_clkdiv.sv
module spi_mm_clkdiv #(
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int CNT_W = (1 << RATE_W) + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;

   // half period = 2^(rate+1) system cycles
   assign half_m1 = (CNT_W'(1) << ({1'b0, rate} + 1'b1)) - CNT_W'(1);
   assign tick    = run && (cnt_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/spi_mm_engine.sv
module spi_mm_engine #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              miso,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_word
);
   typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} st_e;

   st_e               st_q;
   logic              sclk_q, mosi_q;
   logic [LEN_W-1:0]  ptr_q;
   logic [LEN_W:0]    edge_q;
   logic [DATA_W-1:0] rx_sr_q, rx_q;

   logic lead_edge, last_edge, samp_edge, drv_edge;

   assign lead_edge = ~edge_q[0];
   assign last_edge = (edge_q == {len_m1, 1'b1});
   assign samp_edge = lead_edge ^ cpha;
   assign drv_edge  = cpha ? lead_edge : (~lead_edge && !last_edge);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         sclk_q  <= 1'b0;
         mosi_q  <= 1'b0;
         ptr_q   <= '0;
         edge_q  <= '0;
         rx_sr_q <= '0;
         rx_q    <= '0;
      end else if (st_q == ST_IDLE) begin
         if (start) begin
            st_q    <= ST_LEAD;
            sclk_q  <= ~cpol;
            edge_q  <= '0;
            rx_sr_q <= '0;
            if (!cpha) begin
               mosi_q <= tx_word[len_m1];
               ptr_q  <= len_m1 - LEN_W'(1);
            end else begin
               mosi_q <= 1'b0;
               ptr_q  <= len_m1;
            end
         end
      end else if (tick) begin
         if (st_q == ST_TRAIL) begin
            st_q   <= ST_IDLE;
            rx_q   <= rx_sr_q;
            mosi_q <= 1'b0;
         end else begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            if (samp_edge) rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso};
            if (drv_edge) begin
               mosi_q <= tx_word[ptr_q];
               ptr_q  <= ptr_q - LEN_W'(1);
            end
            st_q <= last_edge ? ST_TRAIL : ST_SHIFT;
         end
      end
   end

   assign busy    = (st_q != ST_IDLE);
   assign sclk    = sclk_q;
   assign mosi    = mosi_q;
   assign rx_word = rx_q;
endmodule

// File: rtl/spi_mm_csel.sv
module spi_mm_csel #(
   parameter int NUM_CS = 4,
   parameter int SEL_W  = 2
) (
   input  logic             active,
   input  logic [SEL_W-1:0] sel,
   input  logic             act_hi,
   output logic [NUM_CS-1:0] cs
);
   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs[i] = (active && (sel == SEL_W'(i))) ? act_hi : ~act_hi;
   end
endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master
   import spi_mm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NUM_CS = 4,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs
);
   localparam int IDX_W = ADDR_W - 2;

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("spi_mm_master: DATA_W must equal the control word width");
   end
   if (NUM_CS != (1 << SEL_W)) begin : g_bad_cs
      $error("spi_mm_master: NUM_CS must match the select field");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("spi_mm_master: ADDR_W too small for eight registers");
   end

   logic [IDX_W-1:0]  idx;
   logic              addr_lsb_unused;
   ctl_t              ctl_q, ctl_nxt;
   logic [DATA_W-1:0] tx_q, rx_word;
   logic              busy, wr_ctl, wr_tx, start, tick, eng_sclk;

   assign idx             = bus_addr[ADDR_W-1:2];
   assign addr_lsb_unused = ^bus_addr[1:0];

   assign wr_ctl  = bus_wr && !busy && (idx == IDX_W'(IDX_CTL));
   assign wr_tx   = bus_wr && !busy && (idx == IDX_W'(IDX_TXD));
   assign ctl_nxt = wr_ctl ? ctl_unpack(bus_wdata) : ctl_q;
   assign start   = wr_ctl && bus_wdata[B_GO] && bus_wdata[B_EN] && bus_wdata[B_MST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         tx_q  <= '0;
      end else begin
         ctl_q <= ctl_nxt;
         if (wr_tx) tx_q <= bus_wdata;
      end
   end

   always_comb begin
      if (idx == IDX_W'(IDX_RXD))      bus_rdata = rx_word;
      else if (idx == IDX_W'(IDX_TXD)) bus_rdata = tx_q;
      else if (idx == IDX_W'(IDX_CTL)) bus_rdata = ctl_pack(ctl_q, busy);
      else                             bus_rdata = '0;
   end

   spi_mm_clkdiv #(.RATE_W(RATE_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .rate  (ctl_q.rate),
      .tick  (tick)
   );

   spi_mm_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tick    (tick),
      .cpol    (ctl_nxt.cpol),
      .cpha    (ctl_nxt.cpha),
      .len_m1  (ctl_nxt.len_m1),
      .tx_word (tx_q),
      .miso    (spi_miso),
      .busy    (busy),
      .sclk    (eng_sclk),
      .mosi    (spi_mosi),
      .rx_word (rx_word)
   );

   // outside a frame the clock follows the programmed idle level
   assign spi_sclk = busy ? eng_sclk : ~ctl_q.cpol;

   spi_mm_csel #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
      .active (busy),
      .sel    (ctl_q.sel),
      .act_hi (ctl_q.cspol),
      .cs     (spi_cs)
   );
endmodule

// File: rtl/spi_mm_chk.sv
module spi_mm_chk
   import spi_mm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input ctl_t              ctl_q,
   input logic [DATA_W-1:0] tx_q,
   input logic              spi_sclk,
   input logic              spi_mosi,
   input logic [NUM_CS-1:0] spi_cs
);
   AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(spi_cs ^ {NUM_CS{~ctl_q.cspol}}) <= 1); // R9

   AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (spi_cs == {NUM_CS{~ctl_q.cspol}})); // R9

   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (ctl_q.en && ctl_q.mst)); // R3

   AST_START_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (spi_sclk == ~ctl_q.cpol)); // R7

   AST_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> $stable(spi_sclk)); // R10

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(ctl_q) && $stable(tx_q))); // R11

   AST_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_mosi); // R12
endmodule

bind spi_mm_master spi_mm_chk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .ctl_q    (ctl_q),
   .tx_q     (tx_q),
   .spi_sclk (spi_sclk),
   .spi_mosi (spi_mosi),
   .spi_cs   (spi_cs)
);

// File: tb/spi_mm_master_bench.sv
module spi_mm_master_bench;
   localparam int DW = 32;
   localparam int NCS = 4;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          spi_sclk, spi_mosi;
   logic          spi_miso = 1'b0;
   logic [NCS-1:0] spi_cs;

   spi_mm_master #(.DATA_W(DW), .NUM_CS(NCS), .ADDR_W(AW)) u_spi_mm_master (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mask(input int n);
      logic [63:0] m;
      m = (64'd1 << n) - 64'd1;
      return m[31:0];
   endfunction

   function automatic logic [31:0] ctlw(input bit en, input bit mst, input bit go,
                                        input bit pol, input bit pha, input bit cspol,
                                        input int len_m1, input int rate, input int sel);
      logic [31:0] w;
      w = '0;
      w[0] = en; w[1] = mst; w[2] = go; w[4] = pol; w[5] = pha; w[7] = cspol;
      w[12:8] = len_m1[4:0]; w[18:16] = rate[2:0]; w[25:24] = sel[1:0];
      return w;
   endfunction

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a);
      #1 d = bus_rdata;
   endtask

   // slave model and timing monitor
   int cyc = 0;
   bit m_en = 0;
   int m_sel = 0, m_n = 1, sptr = 0;
   bit m_cspol = 0, m_pha = 0, m_idle = 1;
   logic [31:0] slv = '0, cap = '0;
   int n_edges = 0, gap_bad = 0, other_bad = 0;
   int t_cs_on = 0, t_first = 0, t_last = 0, t_cs_off = 0;
   bit prev_act = 0, prev_sclk = 1;

   always @(negedge clk) begin
      bit act, lead;
      cyc++;
      act = m_en && (spi_cs[m_sel] == m_cspol);
      if (act && !prev_act) begin
         t_cs_on = cyc; n_edges = 0; cap = '0;
         if (!m_pha) begin spi_miso = slv[m_n-1]; sptr = m_n - 2; end
         else sptr = m_n - 1;
      end
      if (act && (spi_sclk != prev_sclk)) begin
         lead = (prev_sclk == m_idle);
         if (n_edges == 0) t_first = cyc;
         else if (cyc - t_last != t_first - t_first + (t_last - t_last) + m_half()) gap_bad++;
         t_last = cyc;
         n_edges++;
         if (lead ^ m_pha) cap = {cap[30:0], spi_mosi};
         else if (sptr >= 0) begin spi_miso = slv[sptr]; sptr--; end
      end
      if (act) begin
         for (int i = 0; i < NCS; i++)
            if (i != m_sel && spi_cs[i] != !m_cspol) other_bad++;
      end
      if (!act && prev_act) t_cs_off = cyc;
      prev_act = act;
      prev_sclk = spi_sclk;
   end

   int m_rate = 0;
   function automatic int m_half();
      return 1 << (m_rate + 1);
   endfunction

   task automatic xfer(input int n, input int rate, input bit pol, input bit pha,
                       input bit cspol, input int sel, input logic [31:0] tx,
                       input logic [31:0] sv, input bit meddle);
      logic [31:0] r;
      int h, k;
      h = 1 << (rate + 1);
      wr(4, tx);
      wr(8, ctlw(1, 1, 0, pol, pha, cspol, n - 1, rate, sel));
      m_en = 1; m_sel = sel; m_cspol = cspol; m_pha = pha; m_idle = ~pol;
      m_n = n; m_rate = rate; slv = sv; gap_bad = 0; other_bad = 0; n_edges = 0;
      repeat (2) @(negedge clk);
      #1;
      chk("R7 idle clock level", {31'd0, spi_sclk}, {31'd0, ~pol});
      chk("R12 data-out low while idle", {31'd0, spi_mosi}, 32'd0);
      chk("R9 selects inactive before frame", {28'd0, spi_cs}, {28'd0, {NCS{~cspol}}});
      wr(8, ctlw(1, 1, 1, pol, pha, cspol, n - 1, rate, sel));
      rd(8, r);
      chk("R2 go bit set during frame", {31'd0, r[2]}, 32'd1);
      if (meddle) begin
         repeat (6) @(negedge clk);
         wr(4, ~tx);
         wr(8, ctlw(1, 1, 1, ~pol, ~pha, ~cspol, 3, 0, sel ^ 1));
      end
      k = 0;
      do begin rd(8, r); k++; end while (r[2] && k < 50000);
      chk("R2 go bit clears", {31'd0, r[2]}, 32'd0);
      chk("R10 select released with go clear", {28'd0, spi_cs}, {28'd0, {NCS{~cspol}}});
      chk("R1 control readback", r, ctlw(1, 1, 0, pol, pha, cspol, n - 1, rate, sel));
      chk("R4 R8 bits seen by slave", cap, tx & mask(n));
      chk("R4 clock transition count", n_edges, 2 * n);
      chk("R6 half period spacing errors", gap_bad, 0);
      chk("R10 select lead time", t_first - t_cs_on, h);
      chk("R10 select trail time", t_cs_off - t_last, h);
      chk("R9 other selects inactive", other_bad, 0);
      rd(0, r);
      chk("R5 receive word", r, sv & mask(n));
      if (meddle) begin
         rd(4, r);
         chk("R11 outgoing word kept", r, tx);
      end
      m_en = 0;
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      int bad;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      for (int a = 0; a < 8; a++) begin
         rd(4 * a, r);
         chk("R1 reset register value", r, 32'd0);
      end
      chk("R9 reset selects", {28'd0, spi_cs}, 32'hF);
      chk("R7 reset clock idles high", {31'd0, spi_sclk}, 32'd1);
      chk("R12 reset data-out", {31'd0, spi_mosi}, 32'd0);
      // field layout and unused offsets
      wr(8, 32'hFFFF_FFFB);
      rd(8, r);
      chk("R1 control unused bits zero", r, 32'h0307_1FB3);
      wr(4, 32'hCAFE_1234);
      rd(4, r);
      chk("R1 outgoing readback", r, 32'hCAFE_1234);
      for (int a = 3; a < 8; a++) begin
         wr(4 * a, 32'hFFFF_FFFF);
         rd(4 * a, r);
         chk("R1 unused offset reads zero", r, 32'd0);
      end
      // gated starts
      wr(8, ctlw(0, 1, 1, 1, 0, 1, 7, 0, 2));
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         if (spi_cs != 4'b0000 || spi_sclk != 1'b0) bad++;
      end
      chk("R3 no activity with enable low", bad, 0);
      rd(8, r);
      chk("R3 go bit not held with enable low", r, ctlw(0, 1, 0, 1, 0, 1, 7, 0, 2));
      wr(8, ctlw(1, 0, 1, 0, 1, 0, 7, 0, 1));
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         if (spi_cs != 4'b1111 || spi_sclk != 1'b1) bad++;
      end
      chk("R3 no activity with master low", bad, 0);
      rd(8, r);
      chk("R3 go bit not held with master low", r, ctlw(1, 0, 0, 0, 1, 0, 7, 0, 1));
      // directed frames
      xfer(32, 0, 1, 0, 0, 0, 32'hA5A5_F00F, 32'h1234_5678, 0);
      xfer(32, 0, 0, 1, 1, 3, 32'h8000_0001, 32'hFEDC_BA98, 0);
      xfer(1, 0, 1, 1, 0, 1, 32'hFFFF_FFFF, 32'h0000_0001, 0);
      xfer(1, 1, 0, 0, 1, 2, 32'h0000_0001, 32'hFFFF_FFFE, 0);
      xfer(8, 7, 0, 0, 1, 2, 32'h0000_00C3, 32'h0000_005A, 0);
      xfer(16, 2, 1, 1, 0, 0, 32'h1357_9BDF, 32'h2468_ACE0, 1);  // R11
      // random frames
      for (int t = 0; t < 14; t++) begin
         xfer(1 + int'($urandom % 32), int'($urandom % 3), bit'($urandom % 2),
              bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 4),
              $urandom, $urandom, bit'($urandom % 4 == 0));
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule